// File: doc/BRIEF.md
# Two-Bucket Ingress Rate Policer

This block judges every frame that enters a switch port against two leaky buckets and decides whether it may pass. A committed bucket and a peak bucket each hold a fill level that grows by the cost of every frame they accept. Each time-base tick drains that fill by the bucket's programmed rate. Configuration is static. A 2-bit field picks how cost is measured: bytes with the interframe gap added, bytes alone, frames at coarse granularity, or frames at fine granularity.

With the committed bucket turned off, the peak bucket alone decides. With it turned on, a frame is first offered to the committed bucket, then to the peak bucket, and it is discarded only when both refuse it. Drain capacity that the committed bucket cannot use, because it is nearly empty, can be passed on to the peak bucket. Either bucket can be pinned full so that it refuses all traffic. A peak rate of all ones with a zero burst turns the policer off, and everything passes.

Top module: `dlb_policer`

## Requirements
- R1: After reset `dec_vld` is 0 and both fills are 0. Exactly one cycle after a cycle with `frm_vld` high, `dec_vld` is 1 and `dec_pass` carries the decision. In every other cycle `dec_vld` is 0.
- R2: In data mode (`cfg_mode` = 1) a frame costs its length in bytes, and a burst unit is 4096 bytes. With overshoot off, a frame passes when fill + cost <= burst × 4096. A passing frame adds its cost to the fill and a dropped frame adds nothing.
- R3: In line mode (`cfg_mode` = 0) the cost is the length plus `cfg_ipg`. The burst unit is 4096 bytes, as in data mode.
- R4: In the frame modes every frame costs 10 fill units. The burst unit is 328 fill units in coarse mode (`cfg_mode` = 2) and 3 fill units in fine mode (`cfg_mode` = 3).
- R5: A `tick` pulse lowers each bucket's fill by its rate, in fill units per tick, and the fill saturates at zero.
- R6: With `cfg_ovs_en` = 1, a frame passes whenever fill < limit, even if its cost carries the fill past the limit.
- R7: A pulse on `force_pk_full` or `force_cm_full` sets that bucket's 23-bit fill to all ones. With a rate of 0 the bucket then rejects every frame, across ticks.
- R8: When `cfg_pir` is all ones and `cfg_pbs` is 0, every frame passes and the peak fill is left unchanged.
- R9: With `cfg_cir_en` = 1, a frame that the committed bucket accepts is charged there. Otherwise it is offered to the peak bucket. It is dropped only when both buckets refuse it.
- R10: With `cfg_cir_en` = 0, the committed bucket plays no part in the decision.
- R11: With `cfg_cir_en` and `cfg_couple` both set, a tick whose committed rate exceeds the committed fill adds the difference to the peak bucket's drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | Frame-start strobe |
| frm_len | input | 16 | Frame length in bytes |
| tick | input | 1 | Time-base drain pulse |
| cfg_mode | input | 2 | Metering mode: 0 line, 1 data, 2 coarse frame, 3 fine frame |
| cfg_ipg | input | 5 | Gap bytes added per frame in line mode |
| cfg_pir | input | 16 | Peak rate |
| cfg_pbs | input | 7 | Peak burst |
| cfg_cir | input | 16 | Committed rate |
| cfg_cbs | input | 7 | Committed burst |
| cfg_cir_en | input | 1 | Enables the committed bucket |
| cfg_couple | input | 1 | Passes unused committed drain on to the peak bucket |
| cfg_ovs_en | input | 1 | Overshoot enable |
| force_pk_full | input | 1 | Pins the peak bucket full |
| force_cm_full | input | 1 | Pins the committed bucket full |
| dec_vld | output | 1 | Decision valid |
| dec_pass | output | 1 | 1 = frame passes, 0 = frame is discarded |

## Verification
The decision is registered, so it is due in the cycle after the frame strobe. The fill update lands on that same edge. The bench drives every strobe on a falling edge, samples `dec_pass` on the next falling edge, and only then issues the next frame, so each decision reflects the fills left by all earlier frames. Ticks and force pulses also last one cycle. Their effect is observed through the next frame's decision rather than by reading fills.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
   typedef enum logic [1:0] {
      MODE_LINE = 2'd0,
      MODE_DATA = 2'd1,
      MODE_FHI  = 2'd2,
      MODE_FLO  = 2'd3
   } meter_mode_e;

   localparam int BYTE_BURST_SHIFT = 12;
   localparam int FHI_BURST_FU     = 328;
   localparam int FLO_BURST_FU     = 3;
   localparam int FRAME_COST_FU    = 10;
endpackage

// File: rtl/dlb_frame_cost.sv
module dlb_frame_cost
   import dlb_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int IPG_W  = 5,
   parameter int FILL_W = 23
) (
   input  meter_mode_e       mode,
   input  logic [LEN_W-1:0]  len,
   input  logic [IPG_W-1:0]  ipg,
   output logic [FILL_W-1:0] cost
);
   if (FILL_W <= LEN_W + 1) begin : g_chk
      $error("dlb_frame_cost: FILL_W too narrow for frame cost");
   end

   always_comb begin
      case (mode)
         MODE_LINE: cost = FILL_W'(len) + FILL_W'(ipg);
         MODE_DATA: cost = FILL_W'(len);
         default:   cost = FILL_W'(FRAME_COST_FU);
      endcase
   end
endmodule

// File: rtl/dlb_burst_limit.sv
module dlb_burst_limit
   import dlb_pkg::*;
#(
   parameter int BURST_W = 7,
   parameter int FILL_W  = 23
) (
   input  meter_mode_e        mode,
   input  logic [BURST_W-1:0] burst,
   output logic [FILL_W-1:0]  limit
);
   if (FILL_W <= BURST_W + BYTE_BURST_SHIFT) begin : g_chk
      $error("dlb_burst_limit: FILL_W too narrow for burst limit");
   end

   always_comb begin
      case (mode)
         MODE_FHI: limit = FILL_W'(burst) * FILL_W'(FHI_BURST_FU);
         MODE_FLO: limit = FILL_W'(burst) * FILL_W'(FLO_BURST_FU);
         default:  limit = FILL_W'(burst) << BYTE_BURST_SHIFT;
      endcase
   end
endmodule

// File: rtl/dlb_bucket.sv
module dlb_bucket #(
   parameter int FILL_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [FILL_W-1:0] leak,
   input  logic              add_en,
   input  logic [FILL_W-1:0] cost,
   input  logic [FILL_W-1:0] limit,
   input  logic              ovs_en,
   input  logic              force_full,
   output logic [FILL_W-1:0] fill_q,
   output logic              conform
);
   logic [FILL_W-1:0] drained;
   logic [FILL_W:0]   summed;
   logic [FILL_W:0]   fill_plus;

   assign fill_plus = {1'b0, fill_q} + {1'b0, cost};
   assign conform   = ovs_en ? (fill_q < limit) : (fill_plus <= {1'b0, limit});

   always_comb begin
      if (tick) drained = (fill_q > leak) ? (fill_q - leak) : '0;
      else      drained = fill_q;
      summed = {1'b0, drained} + (add_en ? {1'b0, cost} : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          fill_q <= '0;
      else if (force_full) fill_q <= '1;
      else if (summed[FILL_W]) fill_q <= '1;
      else                 fill_q <= summed[FILL_W-1:0];
   end

   // R2: a bucket is charged only for frames it accepts
   a_r2_charge_only_conform: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |-> conform);
   // R6: without overshoot an accepted frame never lifts the fill past the limit
   a_r6_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !ovs_en && !force_full) |=> (fill_q <= $past(limit)));
   // R5: with no tick, charge or force the fill holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !add_en && !force_full) |=> $stable(fill_q));
endmodule

// File: rtl/dlb_policer.sv
module dlb_policer
   import dlb_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int IPG_W   = 5,
   parameter int RATE_W  = 16,
   parameter int BURST_W = 7,
   parameter int FILL_W  = 23,
   parameter bit DUAL    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_vld,
   input  logic [LEN_W-1:0]   frm_len,
   input  logic               tick,
   input  logic [1:0]         cfg_mode,
   input  logic [IPG_W-1:0]   cfg_ipg,
   input  logic [RATE_W-1:0]  cfg_pir,
   input  logic [BURST_W-1:0] cfg_pbs,
   input  logic [RATE_W-1:0]  cfg_cir,
   input  logic [BURST_W-1:0] cfg_cbs,
   input  logic               cfg_cir_en,
   input  logic               cfg_couple,
   input  logic               cfg_ovs_en,
   input  logic               force_pk_full,
   input  logic               force_cm_full,
   output logic               dec_vld,
   output logic               dec_pass
);
   if (RATE_W + 1 >= FILL_W) begin : g_chk
      $error("dlb_policer: RATE_W must stay below FILL_W");
   end

   meter_mode_e       mode;
   logic [FILL_W-1:0] cost, pk_limit, pk_leak, pk_fill;
   logic [FILL_W-1:0] cm_surplus;
   logic              pk_ok, cm_ok, cm_use, pk_dis, pass, pk_add;

   assign mode   = meter_mode_e'(cfg_mode);
   assign pk_dis = (&cfg_pir) && (cfg_pbs == '0);

   dlb_frame_cost #(.LEN_W(LEN_W), .IPG_W(IPG_W), .FILL_W(FILL_W)) u_cost (
      .mode(mode), .len(frm_len), .ipg(cfg_ipg), .cost(cost));

   dlb_burst_limit #(.BURST_W(BURST_W), .FILL_W(FILL_W)) u_pk_lim (
      .mode(mode), .burst(cfg_pbs), .limit(pk_limit));

   if (DUAL) begin : g_cm
      logic [FILL_W-1:0] cm_limit, cm_fill, cm_leak;
      logic              cm_add;

      assign cm_use  = cfg_cir_en;
      assign cm_leak = FILL_W'(cfg_cir);
      assign cm_add  = frm_vld && cm_use && cm_ok;
      assign cm_surplus = (tick && cm_use && cfg_couple && (cm_leak > cm_fill)) ?
                          (cm_leak - cm_fill) : '0;

      dlb_burst_limit #(.BURST_W(BURST_W), .FILL_W(FILL_W)) u_cm_lim (
         .mode(mode), .burst(cfg_cbs), .limit(cm_limit));

      dlb_bucket #(.FILL_W(FILL_W)) u_cm (
         .clk(clk), .rst_n(rst_n), .tick(tick), .leak(cm_leak),
         .add_en(cm_add), .cost(cost), .limit(cm_limit), .ovs_en(cfg_ovs_en),
         .force_full(force_cm_full), .fill_q(cm_fill), .conform(cm_ok));

      // R7: forcing the committed bucket leaves it full
      a_r7_cm_forced: assert property (@(posedge clk) disable iff (!rst_n)
         force_cm_full |=> (cm_fill == '1));
   end else begin : g_slb
      assign cm_use     = 1'b0;
      assign cm_ok      = 1'b0;
      assign cm_surplus = '0;
   end

   assign pk_leak = FILL_W'(cfg_pir) + cm_surplus;
   assign pk_add  = frm_vld && !pk_dis && !(cm_use && cm_ok) && pk_ok;
   assign pass    = pk_dis || (cm_use && cm_ok) || pk_ok;

   dlb_bucket #(.FILL_W(FILL_W)) u_pk (
      .clk(clk), .rst_n(rst_n), .tick(tick), .leak(pk_leak),
      .add_en(pk_add), .cost(cost), .limit(pk_limit), .ovs_en(cfg_ovs_en),
      .force_full(force_pk_full), .fill_q(pk_fill), .conform(pk_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_vld  <= 1'b0;
         dec_pass <= 1'b0;
      end else begin
         dec_vld  <= frm_vld;
         dec_pass <= frm_vld && pass;
      end
   end

   // R1: one decision per frame, one cycle later
   a_r1_dec_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> dec_vld);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> !dec_vld);
   // R8: disabled policer passes everything
   a_r8_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && (&cfg_pir) && (cfg_pbs == '0)) |=> dec_pass);
   // R7: forcing the peak bucket leaves it full
   a_r7_pk_forced: assert property (@(posedge clk) disable iff (!rst_n)
      force_pk_full |=> (pk_fill == '1));
endmodule

// File: tb/dlb_policer_bench.sv
module dlb_policer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // data mode, one burst unit (4096 bytes), no overshoot, zero rate
   localparam logic [15:0] VLEN [NVEC] = '{16'd1500, 16'd1500, 16'd1500,
                                           16'd1000, 16'd96, 16'd1};
   localparam logic        VEXP [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frm_vld = 1'b0, tick = 1'b0;
   logic [15:0] frm_len = '0;
   logic [1:0]  cfg_mode = 2'd1;
   logic [4:0]  cfg_ipg = '0;
   logic [15:0] cfg_pir = '0, cfg_cir = '0;
   logic [6:0]  cfg_pbs = 7'd1, cfg_cbs = '0;
   logic cfg_cir_en = 1'b0, cfg_couple = 1'b0, cfg_ovs_en = 1'b0;
   logic force_pk_full = 1'b0, force_cm_full = 1'b0;
   logic dec_vld, dec_pass;
   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dlb_policer u_dlb_policer (
      .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_len(frm_len), .tick(tick),
      .cfg_mode(cfg_mode), .cfg_ipg(cfg_ipg), .cfg_pir(cfg_pir), .cfg_pbs(cfg_pbs),
      .cfg_cir(cfg_cir), .cfg_cbs(cfg_cbs), .cfg_cir_en(cfg_cir_en),
      .cfg_couple(cfg_couple), .cfg_ovs_en(cfg_ovs_en),
      .force_pk_full(force_pk_full), .force_cm_full(force_cm_full),
      .dec_vld(dec_vld), .dec_pass(dec_pass));

   task automatic check(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      cfg_mode = 2'd1; cfg_ipg = '0; cfg_pir = '0; cfg_pbs = 7'd1;
      cfg_cir = '0; cfg_cbs = '0; cfg_cir_en = 1'b0; cfg_couple = 1'b0;
      cfg_ovs_en = 1'b0; force_pk_full = 1'b0; force_cm_full = 1'b0;
      frm_vld = 1'b0; tick = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic send(input logic [15:0] len, input logic exp, input string tag);
      @(negedge clk); frm_len = len; frm_vld = 1'b1;
      @(negedge clk); frm_vld = 1'b0;
      check(tag, dec_pass, exp);
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state and strobe timing
      @(negedge clk); check("R1 idle after reset", dec_vld, 1'b0);
      @(negedge clk); frm_len = 16'd64; frm_vld = 1'b1;
      @(negedge clk); frm_vld = 1'b0;
      check("R1 valid one cycle later", dec_vld, 1'b1);
      @(negedge clk); check("R1 valid drops", dec_vld, 1'b0);

      // R2: table walk in data mode, limit 4096
      do_reset();
      for (int i = 0; i < NVEC; i++) send(VLEN[i], VEXP[i], "R2 data-mode vector");

      // R3: line mode, ipg 20 added
      do_reset(); cfg_mode = 2'd0; cfg_ipg = 5'd20;
      send(16'd4077, 1'b0, "R3 line cost 4097 over limit");
      send(16'd4076, 1'b1, "R3 line cost 4096 at limit");
      send(16'd1, 1'b0, "R3 line bucket full");

      // R4: coarse frame mode, limit 328, 10 per frame
      do_reset(); cfg_mode = 2'd2;
      for (int i = 0; i < 32; i++) send(16'd1500, 1'b1, "R4 coarse frame within burst");
      send(16'd64, 1'b0, "R4 coarse frame 33rd over limit");
      // R4: fine frame mode, burst 4 -> limit 12
      do_reset(); cfg_mode = 2'd3; cfg_pbs = 7'd4;
      send(16'd64, 1'b1, "R4 fine first frame");
      send(16'd64, 1'b0, "R4 fine second frame over limit");

      // R6: overshoot in fine frame mode and data mode
      do_reset(); cfg_mode = 2'd3; cfg_pbs = 7'd4; cfg_ovs_en = 1'b1;
      send(16'd64, 1'b1, "R6 fine first");
      send(16'd64, 1'b1, "R6 fine overshoot allowed");
      send(16'd64, 1'b0, "R6 fine fill at limit");
      do_reset(); cfg_ovs_en = 1'b1;
      send(16'd4000, 1'b1, "R6 data first");
      send(16'd4000, 1'b1, "R6 data overshoot");
      send(16'd1, 1'b0, "R6 data over limit");

      // R5: drain by rate per tick, saturating
      do_reset(); cfg_pir = 16'd100;
      send(16'd4096, 1'b1, "R5 fill to limit");
      send(16'd1, 1'b0, "R5 full before tick");
      pulse_tick();
      send(16'd100, 1'b1, "R5 room after one tick");
      send(16'd1, 1'b0, "R5 full again");
      cfg_pir = 16'd60000; pulse_tick(); cfg_pir = 16'd0;
      send(16'd4096, 1'b1, "R5 saturated at zero");

      // R7: forced full
      do_reset(); cfg_pbs = 7'd60;
      @(negedge clk); force_pk_full = 1'b1;
      @(negedge clk); force_pk_full = 1'b0;
      send(16'd64, 1'b0, "R7 forced peak drops");
      pulse_tick();
      send(16'd64, 1'b0, "R7 forced peak after tick");
      do_reset(); cfg_cir_en = 1'b1; cfg_cbs = 7'd1; cfg_pbs = 7'd0;
      @(negedge clk); force_cm_full = 1'b1;
      @(negedge clk); force_cm_full = 1'b0;
      send(16'd64, 1'b0, "R7 forced committed drops");

      // R8: disabled policer
      do_reset(); cfg_pir = 16'hFFFF; cfg_pbs = 7'd0;
      for (int i = 0; i < 3; i++) send(16'd9000, 1'b1, "R8 disabled passes");

      // R9: committed first, then peak
      do_reset(); cfg_cir_en = 1'b1; cfg_cbs = 7'd1;
      send(16'd4096, 1'b1, "R9 committed takes frame");
      send(16'd4096, 1'b1, "R9 peak takes frame");
      send(16'd1, 1'b0, "R9 both full");

      // R10: committed ignored when disabled
      do_reset(); cfg_cbs = 7'd1;
      send(16'd4096, 1'b1, "R10 peak takes frame");
      send(16'd4096, 1'b0, "R10 committed not used");

      // R11: coupling of unused committed drain
      do_reset(); cfg_cir_en = 1'b1; cfg_cir = 16'd100; cfg_couple = 1'b1;
      send(16'd4096, 1'b1, "R11 peak filled");
      send(16'd1, 1'b0, "R11 peak full");
      pulse_tick();
      send(16'd100, 1'b1, "R11 coupled drain frees room");
      send(16'd1, 1'b0, "R11 full again");
      do_reset(); cfg_cir_en = 1'b1; cfg_cir = 16'd100;
      send(16'd4096, 1'b1, "R11 uncoupled peak filled");
      pulse_tick();
      send(16'd100, 1'b0, "R11 no coupling no room");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule